// File: doc/BRIEF.md
# Flash Controller Interrupt Aggregator

This block gathers the completion events of a serial flash controller into one three-bit status register and drives a single level-sensitive interrupt line. Two events come in as one-cycle pulses: a programmed-I/O transfer has finished, and a DMA transfer has finished. The third event is produced inside the block by a receive byte counter. It fires when the number of bytes received from the flash reaches a threshold of 32 or 64 bytes, chosen by a configuration input.

Software reaches the block through a small register port with one address bit. Address 0 is the status register: reads return the pending events, and writes clear every bit written as 1. Address 1 is the mask register, which can be read and written. A masked event still records its status bit but does not drive the line. The interrupt output is the OR of all pending status bits whose mask bit is clear.

Top module: `flash_irq_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the status register reads 3'b000, the mask register reads 3'b111, irq_o is low, and the receive byte count is zero.
- R2: A pio_done_i pulse sets status bit 2, which reads back as 1 from the clock edge that samples the pulse onward.
- R3: A dma_done_i pulse sets status bit 1, which reads back as 1 from the clock edge that samples the pulse onward.
- R4: Status bit 0 is set at the edge that samples the rx_byte_i strobe that brings the receive count to the threshold. The threshold is 32 bytes when thr_small_i is 1 and 64 bytes when it is 0.
- R5: The receive count returns to zero when the threshold is reached and when xfer_start_i is high. A byte strobe that arrives in the same cycle as xfer_start_i is not counted. The threshold counts as reached when the incremented count is at least the currently selected threshold, so a byte after a switch from 64 to 32 with more than 31 bytes counted sets bit 0.
- R6: A write to address 0 clears each status bit whose write-data bit is 1 and leaves bits written as 0 unchanged. Reading address 0 returns the status bits.
- R7: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R8: A write to address 1 loads the mask register with reg_wdata_i, and reading address 1 returns it. Bit positions are the same as in the status register: 2 = programmed I/O, 1 = DMA, 0 = receive threshold.
- R9: irq_o is high exactly when some status bit is 1 and its mask bit is 0. A masked event still sets its status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pio_done_i | input | 1 | One-cycle pulse: programmed-I/O transfer finished |
| dma_done_i | input | 1 | One-cycle pulse: DMA transfer finished |
| rx_byte_i | input | 1 | One cycle per byte received from the flash |
| xfer_start_i | input | 1 | New transfer starts; clears the receive count |
| thr_small_i | input | 1 | Threshold select: 1 = 32 bytes, 0 = 64 bytes |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = status, 1 = mask |
| reg_wdata_i | input | 3 | Write data |
| reg_rdata_o | output | 3 | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest situations to reach from the ports all involve the receive counter. It has no readable state, so it shows up only through status bit 0 after long runs of byte strobes. Examples are a threshold switch after more than 32 bytes have been counted, and a start that coincides with a byte strobe. The stimulus drives exact strobe counts one short of each threshold, then the single strobe that crosses it. It also interleaves start pulses and threshold changes at chosen counts. A long pseudo-random phase follows, in which a cycle-by-cycle behavioural model tracks the count and catches any divergence.

// File: rtl/flash_irq_pkg.sv
// Shared constants for the flash interrupt aggregator.
// Assumes: status and mask use the same bit positions.
package flash_irq_pkg;
    localparam int EVT_NUM   = 3;
    localparam int EVT_RXTHR = 0;
    localparam int EVT_DMA   = 1;
    localparam int EVT_PIO   = 2;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/rx_thresh_counter.sv
// Counts received bytes and pulses hit_o on the byte that reaches the
// selected threshold (SMALL_THR or BIG_THR). Clears on hit and on start.
// Assumes: start_i has priority; a byte seen together with start is dropped.
module rx_thresh_counter #(
    parameter int SMALL_THR = 32,
    parameter int BIG_THR   = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic byte_i,
    input  logic sel_small_i,
    output logic hit_o
);
    localparam int CNT_W = $clog2(BIG_THR + 1);
    localparam logic [CNT_W-1:0] SMALL_V = CNT_W'(SMALL_THR);
    localparam logic [CNT_W-1:0] BIG_V   = CNT_W'(BIG_THR);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] thr_v;

    // Select threshold and form the incremented count.
    always_comb begin
        thr_v   = sel_small_i ? SMALL_V : BIG_V;
        cnt_inc = cnt_q + CNT_W'(1);
        hit_o   = byte_i && !start_i && (cnt_inc >= thr_v);
    end

    // Byte count register: cleared by start or threshold hit.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start_i)        cnt_q <= '0;
        else if (hit_o)          cnt_q <= '0;
        else if (byte_i)         cnt_q <= cnt_inc;
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < BIG_V);
    // R5
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_q == '0));
endmodule

// File: rtl/irq_status_bits.sv
// Sticky event status bits with write-one-to-clear.
// Assumes: a set and a clear on the same bit in one cycle leave it set.
module irq_status_bits #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] sts_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // One sticky bit: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        sts_o[i] <= 1'b0;
            else if (set_i[i]) sts_o[i] <= 1'b1;
            else if (clr_i[i]) sts_o[i] <= 1'b0;
        end

        // R7
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> sts_o[i]);
        // R6
        clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !sts_o[i]);
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Software-written mask register; a 1 blocks the matching event from irq.
// Assumes: resets to all masked.
module irq_mask_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] mask_o
);
    // Mask storage, loaded on write.
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_o <= '1;
        else if (wr_i) mask_o <= wdata_i;
    end

    // R8
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (mask_o == $past(wdata_i)));
endmodule

// File: rtl/flash_irq_unit.sv
// Top: collects programmed-I/O done, DMA done and receive-threshold events
// into a status register and drives a level interrupt through a mask.
// Assumes: event inputs are single-cycle pulses in the clk domain.
module flash_irq_unit
    import flash_irq_pkg::*;
#(
    parameter int SMALL_THR = 32,
    parameter int BIG_THR   = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pio_done_i,
    input  logic                dma_done_i,
    input  logic                rx_byte_i,
    input  logic                xfer_start_i,
    input  logic                thr_small_i,
    input  logic                reg_wr_i,
    input  logic                reg_addr_i,
    input  logic [EVT_NUM-1:0]  reg_wdata_i,
    output logic [EVT_NUM-1:0]  reg_rdata_o,
    output logic                irq_o
);
    logic               rx_hit;
    logic [EVT_NUM-1:0] evt_set;
    logic [EVT_NUM-1:0] evt_clr;
    logic [EVT_NUM-1:0] sts;
    logic [EVT_NUM-1:0] msk;
    logic               wr_sts;
    logic               wr_msk;

    rx_thresh_counter #(
        .SMALL_THR (SMALL_THR),
        .BIG_THR   (BIG_THR)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (xfer_start_i),
        .byte_i      (rx_byte_i),
        .sel_small_i (thr_small_i),
        .hit_o       (rx_hit)
    );

    // Decode register writes and assemble event vector.
    always_comb begin
        wr_sts              = reg_wr_i && (reg_sel_e'(reg_addr_i) == SEL_STATUS);
        wr_msk              = reg_wr_i && (reg_sel_e'(reg_addr_i) == SEL_MASK);
        evt_clr             = wr_sts ? reg_wdata_i : '0;
        evt_set             = '0;
        evt_set[EVT_PIO]    = pio_done_i;
        evt_set[EVT_DMA]    = dma_done_i;
        evt_set[EVT_RXTHR]  = rx_hit;
    end

    irq_status_bits #(.N(EVT_NUM)) u_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_set),
        .clr_i (evt_clr),
        .sts_o (sts)
    );

    irq_mask_reg #(.N(EVT_NUM)) u_msk (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_msk),
        .wdata_i (reg_wdata_i),
        .mask_o  (msk)
    );

    // Read mux and level interrupt.
    always_comb begin
        reg_rdata_o = (reg_sel_e'(reg_addr_i) == SEL_MASK) ? msk : sts;
        irq_o       = |(sts & ~msk);
    end

    // R4
    rx_hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_hit |=> sts[EVT_RXTHR]);
endmodule

// File: tb/sim_flash_irq_unit.sv
module sim_flash_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pio_done_i = 1'b0, dma_done_i = 1'b0, rx_byte_i = 1'b0;
    logic       xfer_start_i = 1'b0, thr_small_i = 1'b1;
    logic       reg_wr_i = 1'b0, reg_addr_i = 1'b0;
    logic [2:0] reg_wdata_i = 3'b000;
    logic [2:0] reg_rdata_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    logic [2:0] m_sts;
    logic [2:0] m_msk;
    int         m_cnt;

    always #10 clk = ~clk;

    flash_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .pio_done_i(pio_done_i), .dma_done_i(dma_done_i),
        .rx_byte_i(rx_byte_i), .xfer_start_i(xfer_start_i), .thr_small_i(thr_small_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        logic hit;
        int   thr;
        if (!rst_n) begin
            m_sts = 3'b000; m_msk = 3'b111; m_cnt = 0;
        end else begin
            hit = 1'b0;
            thr = thr_small_i ? 32 : 64;
            if (xfer_start_i) m_cnt = 0;
            else if (rx_byte_i) begin
                if (m_cnt + 1 >= thr) begin hit = 1'b1; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end
            if (reg_wr_i && reg_addr_i == 1'b0) m_sts = m_sts & ~reg_wdata_i;
            m_sts = m_sts | {pio_done_i, dma_done_i, hit};
            if (reg_wr_i && reg_addr_i == 1'b1) m_msk = reg_wdata_i;
        end
    end

    // compare against the model every cycle, 2 ns after the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            check("R9 irq", int'(irq_o), int'(|(m_sts & ~m_msk)));
            if (reg_addr_i) check("R8 mask read", int'(reg_rdata_o), int'(m_msk));
            else            check("R6 status read", int'(reg_rdata_o), int'(m_sts));
        end
    end

    task automatic step();
        @(posedge clk); #5;
    endtask

    task automatic rd(input logic a, output logic [2:0] v);
        reg_addr_i = a; #1; v = reg_rdata_o;
    endtask

    task automatic bytes(input int n);
        rx_byte_i = 1'b1;
        repeat (n) step();
        rx_byte_i = 1'b0;
    endtask

    task automatic w(input logic a, input logic [2:0] d);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        step();
        reg_wr_i = 1'b0; reg_wdata_i = 3'b000;
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [2:0] v;
        #5;
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        rd(1'b0, v); check("R1 status", int'(v), 0);
        rd(1'b1, v); check("R1 mask", int'(v), 7);
        check("R1 irq", int'(irq_o), 0);
        // R2 pio event while masked
        pio_done_i = 1'b1; step(); pio_done_i = 1'b0;
        rd(1'b0, v); check("R2 pio bit", int'(v), 4);
        check("R9 masked irq low", int'(irq_o), 0);
        // R3 dma event
        dma_done_i = 1'b1; step(); dma_done_i = 1'b0;
        rd(1'b0, v); check("R3 dma bit", int'(v), 6);
        // R8 unmask all
        w(1'b1, 3'b000);
        rd(1'b1, v); check("R8 mask", int'(v), 0);
        check("R9 irq high", int'(irq_o), 1);
        // R6 clear bit 1 only
        w(1'b0, 3'b010);
        rd(1'b0, v); check("R6 w1c partial", int'(v), 4);
        // R7 set beats clear
        pio_done_i = 1'b1; w(1'b0, 3'b100); pio_done_i = 1'b0;
        rd(1'b0, v); check("R7 set wins", int'(v), 4);
        w(1'b0, 3'b100);
        rd(1'b0, v); check("R6 cleared", int'(v), 0);
        check("R9 irq low", int'(irq_o), 0);
        // R4 32-byte threshold
        thr_small_i = 1'b1;
        xfer_start_i = 1'b1; step(); xfer_start_i = 1'b0;
        bytes(31); rd(1'b0, v); check("R4 31 of 32", int'(v), 0);
        bytes(1);  rd(1'b0, v); check("R4 32 of 32", int'(v), 1);
        w(1'b0, 3'b001);
        // R4 64-byte threshold
        thr_small_i = 1'b0;
        bytes(63); rd(1'b0, v); check("R4 63 of 64", int'(v), 0);
        bytes(1);  rd(1'b0, v); check("R4 64 of 64", int'(v), 1);
        w(1'b0, 3'b001);
        // R5 start clears count
        thr_small_i = 1'b1;
        bytes(10);
        xfer_start_i = 1'b1; step(); xfer_start_i = 1'b0;
        bytes(31); rd(1'b0, v); check("R5 start clears", int'(v), 0);
        bytes(1);  rd(1'b0, v); check("R5 hit after start", int'(v), 1);
        w(1'b0, 3'b001);
        // R5 byte with start is dropped
        xfer_start_i = 1'b1; rx_byte_i = 1'b1; step(); xfer_start_i = 1'b0;
        bytes(31); rd(1'b0, v); check("R5 byte dropped", int'(v), 0);
        bytes(1);  rd(1'b0, v); check("R5 hit on 32nd", int'(v), 1);
        w(1'b0, 3'b001);
        // R5 threshold switch 64 -> 32 with 40 counted
        thr_small_i = 1'b0;
        bytes(40); rd(1'b0, v); check("R5 40 of 64", int'(v), 0);
        thr_small_i = 1'b1;
        bytes(1);  rd(1'b0, v); check("R5 switch hit", int'(v), 1);
        w(1'b0, 3'b111);
        // pseudo-random phase, compared by the model each cycle
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] r;
            r = $urandom;
            pio_done_i   = (r[3:0] == 4'd0);
            dma_done_i   = (r[7:4] == 4'd0);
            rx_byte_i    = r[8] | r[9];
            xfer_start_i = (r[15:10] == 6'd0);
            if (r[21:16] == 6'd0) thr_small_i = ~thr_small_i;
            reg_wr_i     = (r[25:22] == 4'd0);
            reg_addr_i   = r[26];
            reg_wdata_i  = r[29:27];
            step();
        end
        pio_done_i = 1'b0; dma_done_i = 1'b0; rx_byte_i = 1'b0;
        xfer_start_i = 1'b0; reg_wr_i = 1'b0;
        step();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule